// File: doc/BRIEF.md
# Bad-Block Marker Byte Swapper

This block sits beside the page buffer of a NAND controller. On a large page, the buffer holds four 512-byte main sections and four small spare sections. The flash device expects its factory bad-block marker at a byte that, in this layout, falls inside the last main section. The block exchanges one byte between that main word and one word of the last spare section, so the marker ends up where the device looks for it.

The block runs once for each page transfer. On a read, it runs after all four sections have been loaded into the buffer. On a program, it runs before the data-input transfers begin. When it runs, it reads the two words over a word-wide buffer port, writes back the two recombined words, and pulses `done`. When the swap is switched off, or the page is the small 512-byte size, it reports completion at once and leaves the buffer alone.

Top module: `bb_swap_top`

## Requirements
- R1: While reset is held, and after it is released with no `start`, `done`, `memRe` and `memWe` are all 0.
- R2: When `start` is sampled with `swapEn` = 0, `done` is 1 in the next cycle for exactly one cycle, and the buffer port makes no read and no write.
- R3: When `start` is sampled with `largePage` = 0 (the 512-byte page size), `done` is 1 in the next cycle, and there is no buffer access.
- R4: When `start` is sampled with `swapEn` = 1 and `largePage` = 1, the block makes exactly two reads on the two following cycles. The first read is at main word address 1000, which is byte 464 of the fourth 512-byte main section. The second read is at spare word address 1050, which is byte 4 of the fourth 16-byte spare section above byte 2048.
- R5: After the reads, the main word is written back with its own upper byte [15:8] unchanged and with the spare word's upper byte as its lower byte [7:0].
- R6: In the next cycle, the spare word is written with the original main word's lower byte as its upper byte and with its own lower byte unchanged.
- R7: With `isProgram` = 1, the value read from the spare word is replaced by 0xFFFF before recombination. The main word then gets 0xFF in [7:0], and the spare word gets 0xFF in [7:0].
- R8: `done` is a single-cycle pulse in the cycle after the second write, which is the fifth cycle after `start` is sampled. There are exactly two writes.
- R9: A `start` that arrives while an operation is in progress is ignored, so the two words are exchanged only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one operation (pulse) |
| swapEn | input | 1 | 1 = perform the marker exchange |
| largePage | input | 1 | 1 = four-section large page, 0 = 512-byte page |
| isProgram | input | 1 | 1 = program direction, 0 = read direction; held stable during an operation |
| memAddr | output | 12 | Buffer word address |
| memRe | output | 1 | Buffer read strobe; data returns one cycle later |
| memWe | output | 1 | Buffer write strobe |
| memWdata | output | 16 | Buffer write data |
| memRdata | input | 16 | Buffer read data, valid the cycle after `memRe` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the byte lanes. It uses word pairs whose upper and lower bytes all differ, so a design that takes a low byte where a high byte belongs, or writes the same lane back, produces a visibly wrong main or spare word. Program-direction vectors check that the spare contents read back are discarded. A design that used the stale spare value would leave a non-0xFF byte in either word. The bench checks the bypass cases for both disable and small page, and a repeated `start` while the block is busy. A design that touched the buffer on a bypass, or that ran the exchange twice, would show extra accesses, or the main word would be left holding the original main word's low byte.

// File: rtl/bb_swap_pkg.sv
package bb_swap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_MAIN, ST_RD_SPARE, ST_WR_MAIN, ST_WR_SPARE, ST_FIN
  } swapState_t;

  typedef struct packed {
    logic rdMain;
    logic rdSpare;
    logic wrMain;
    logic wrSpare;
  } swapStrobe_t;
endpackage

// File: rtl/bb_swap_ctrl.sv
module bb_swap_ctrl
  import bb_swap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        swapEn,
  input  logic        largePage,
  output swapStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  swapState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (start) stateNext = (swapEn && largePage) ? ST_RD_MAIN : ST_FIN;
      ST_RD_MAIN:  stateNext = ST_RD_SPARE;
      ST_RD_SPARE: stateNext = ST_WR_MAIN;
      ST_WR_MAIN:  stateNext = ST_WR_SPARE;
      ST_WR_SPARE: stateNext = ST_FIN;
      ST_FIN:      stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.rdMain  = (state == ST_RD_MAIN);
    strobe.rdSpare = (state == ST_RD_SPARE);
    strobe.wrMain  = (state == ST_WR_MAIN);
    strobe.wrSpare = (state == ST_WR_SPARE);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/bb_swap_dp.sv
module bb_swap_dp
  import bb_swap_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 12,
  parameter int MAIN_WADDR   = 1000,
  parameter int SPARE_WADDR  = 1050
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapStrobe_t       strobe,
  input  logic              isProgram,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata
);
  localparam int HALF = DATA_W / 2;
  localparam logic [ADDR_W-1:0] MAIN_A  = ADDR_W'(MAIN_WADDR);
  localparam logic [ADDR_W-1:0] SPARE_A = ADDR_W'(SPARE_WADDR);

  logic [DATA_W-1:0] mainQ, spareQ, spareEff;

  // Program direction discards whatever the spare word held.
  assign spareEff = isProgram ? {DATA_W{1'b1}} : memRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainQ  <= '0;
      spareQ <= '0;
    end else begin
      if (strobe.rdSpare) mainQ  <= memRdata;   // main data returns now
      if (strobe.wrMain)  spareQ <= spareEff;   // spare data returns now
    end
  end

  always_comb begin
    memRe    = strobe.rdMain | strobe.rdSpare;
    memWe    = strobe.wrMain | strobe.wrSpare;
    memAddr  = '0;
    memWdata = '0;
    if (strobe.rdMain || strobe.wrMain)   memAddr = MAIN_A;
    if (strobe.rdSpare || strobe.wrSpare) memAddr = SPARE_A;
    if (strobe.wrMain)  memWdata = {mainQ[DATA_W-1:HALF], spareEff[DATA_W-1:HALF]};
    if (strobe.wrSpare) memWdata = {mainQ[HALF-1:0], spareQ[HALF-1:0]};
  end
endmodule

// File: rtl/bb_swap_top.sv
module bb_swap_top
  import bb_swap_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 12,
  parameter int MAIN_SECT_B  = 512,
  parameter int SPARE_SECT_B = 16,
  parameter int MAIN_BASE_B  = 0,
  parameter int SPARE_BASE_B = 2048,
  parameter int LAST_SECT    = 3,
  parameter int MAIN_OFS_B   = 464,
  parameter int SPARE_OFS_B  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              swapEn,
  input  logic              largePage,
  input  logic              isProgram,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done
);
  localparam int WORD_B      = DATA_W / 8;
  localparam int MAIN_WADDR  = (MAIN_BASE_B + LAST_SECT * MAIN_SECT_B + MAIN_OFS_B) / WORD_B;
  localparam int SPARE_WADDR = (SPARE_BASE_B + LAST_SECT * SPARE_SECT_B + SPARE_OFS_B) / WORD_B;

  swapStrobe_t strobe;
  logic        busy;

  bb_swap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .swapEn(swapEn),
    .largePage(largePage), .strobe(strobe), .busy(busy), .done(done)
  );

  bb_swap_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .MAIN_WADDR(MAIN_WADDR), .SPARE_WADDR(SPARE_WADDR)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isProgram(isProgram),
    .memRdata(memRdata), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata)
  );
endmodule

// File: rtl/bb_swap_chk.sv
module bb_swap_chk #(
  parameter int ADDR_W      = 12,
  parameter int MAIN_WADDR  = 1000,
  parameter int SPARE_WADDR = 1050
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              swapEn,
  input logic              largePage,
  input logic              busy,
  input logic              memRe,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done
);
  localparam logic [ADDR_W-1:0] MAIN_A  = ADDR_W'(MAIN_WADDR);
  localparam logic [ADDR_W-1:0] SPARE_A = ADDR_W'(SPARE_WADDR);

  // R2
  bypass_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !swapEn) |=> (done && !memRe && !memWe));

  // R3
  small_page_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !largePage) |=> (done && !memRe && !memWe));

  // R4
  first_read_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && swapEn && largePage) |=> (memRe && memAddr == MAIN_A));

  // R4
  second_read_spare_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && memAddr == MAIN_A) |=> (memRe && memAddr == SPARE_A));

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr == SPARE_A) |=> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe) && !(done && (memRe || memWe)));
endmodule

bind bb_swap_top bb_swap_chk #(
  .ADDR_W(ADDR_W), .MAIN_WADDR(MAIN_WADDR), .SPARE_WADDR(SPARE_WADDR)
) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .swapEn(swapEn),
  .largePage(largePage), .busy(busy), .memRe(memRe), .memWe(memWe),
  .memAddr(memAddr), .done(done)
);

// File: tb/test_bb_swap_top.sv
module test_bb_swap_top;
  localparam int MAIN_A  = 1000;
  localparam int SPARE_A = 1050;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, swapEn = 1'b0, largePage = 1'b0, isProgram = 1'b0;
  logic [11:0] memAddr;
  logic        memRe, memWe, done;
  logic [15:0] memWdata, memRdata;
  logic [15:0] mem [4096];

  int checks = 0, failures = 0;
  int nRd = 0, nWr = 0;

  always #2.5 clk = ~clk;

  bb_swap_top i_bb_swap_top (
    .clk(clk), .rstN(rstN), .start(start), .swapEn(swapEn),
    .largePage(largePage), .isProgram(isProgram), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .done(done)
  );

  always_ff @(posedge clk) begin
    if (memWe) begin mem[memAddr] <= memWdata; nWr <= nWr + 1; end
    if (memRe) begin memRdata <= mem[memAddr]; nRd <= nRd + 1; end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // {largePage, swapEn, isProgram, mainInit, spareInit, expMain, expSpare}
  localparam logic [66:0] VEC [7] = '{
    {3'b110, 16'hA1B2, 16'hC3D4, 16'hA1C3, 16'hB2D4},
    {3'b111, 16'h1234, 16'h5678, 16'h12FF, 16'h34FF},
    {3'b100, 16'h55AA, 16'h0F0F, 16'h55AA, 16'h0F0F},
    {3'b010, 16'h9ABC, 16'hDEF0, 16'h9ABC, 16'hDEF0},
    {3'b001, 16'h2468, 16'h1357, 16'h2468, 16'h1357},
    {3'b110, 16'h8001, 16'h7F80, 16'h807F, 16'h0180},
    {3'b111, 16'h00C5, 16'h3C3C, 16'h00FF, 16'hC5FF}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int k;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", done, 0);
    check("R1 re/we", {memRe, memWe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {done, memRe, memWe}, 0);

    for (int v = 0; v < 7; v++) begin
      logic big, en;
      big = VEC[v][66]; en = VEC[v][65];
      mem[MAIN_A]  = VEC[v][63:48];
      mem[SPARE_A] = VEC[v][47:32];
      largePage = big; swapEn = en; isProgram = VEC[v][64];
      nRd = 0; nWr = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      do begin
        if (k > 0) @(negedge clk);
        k++;
      end while (!done && k < 10);
      if (big && en) begin
        // R4 R5 R6 R7 R8
        check("R8 done cycle", k, 5);
        check("R4 reads", nRd, 2);
        check("R8 writes", nWr, 2);
        check(VEC[v][64] ? "R7 main word" : "R5 main word", mem[MAIN_A], VEC[v][31:16]);
        check(VEC[v][64] ? "R7 spare word" : "R6 spare word", mem[SPARE_A], VEC[v][15:0]);
      end else begin
        // R2 R3
        check(en ? "R3 done cycle" : "R2 done cycle", k, 1);
        check(en ? "R3 no access" : "R2 no access", nRd + nWr, 0);
        check("R2 R3 main untouched", mem[MAIN_A], VEC[v][31:16]);
        check("R2 R3 spare untouched", mem[SPARE_A], VEC[v][15:0]);
      end
      @(negedge clk);
      check("R8 done single pulse", done, 0);
      @(negedge clk);
    end

    // R9: start held high across a busy operation is honoured once only
    mem[MAIN_A] = 16'h1122; mem[SPARE_A] = 16'h3344;
    largePage = 1'b1; swapEn = 1'b1; isProgram = 1'b0;
    nRd = 0; nWr = 0;
    start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    k = 4;
    while (!done && k < 10) begin @(negedge clk); k++; end
    check("R9 done cycle", k, 5);
    check("R9 single read pair", nRd, 2);
    check("R9 main once", mem[MAIN_A], 16'h1133);
    check("R9 spare once", mem[SPARE_A], 16'h2244);
    repeat (3) @(negedge clk);
    check("R9 no restart", nRd + nWr, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule